// File: doc/BRIEF.md
# Calendar Register Write Guard

This block sits between a simple register bus and the core of a timekeeping peripheral. It keeps the calendar and configuration registers from being changed by accident. A write to a protected register only takes effect after software has written a two-value unlock key, in order, to a key register. Any write to the key register that breaks the sequence locks the block again.

To load a new time, date or prescaler, software first unlocks the block and then sets an init request bit. After a short synchronising delay the block raises a ready flag and holds the calendar core frozen. Only while that flag is set are time, date and prescaler writes accepted. Accepted time and date writes reach the core as one-cycle load strobes that carry the written word.

When the calendar is not frozen, each refresh tick from the core copies the live time and date into shadow registers and sets a synced flag. Software clears that flag and then polls until it is set again, which tells it that the shadow copies are fresh. A bypass bit in the control register makes time and date reads return the live values directly, so no wait on the synced flag is needed.

Top module: `calendar_write_guard`

## Requirements
- R1: After reset the block is locked, the init request, ready and synced flags are 0, the prescaler equals PRESC_RST (default 0x7F00FF), the control register is 0, both load strobes are low and load_data_o is 0.
- R2: The block unlocks when the key register (offset 0x24) receives a write whose low byte is 0xCA, followed directly by a key write whose low byte is 0x53. The upper bits of a key write are ignored. Once unlocked, writes to the control register (offset 0x18) and to the init bit take effect.
- R3: From the locked state, a key write other than 0xCA leaves the block locked. After a first 0xCA, any second key write other than 0x53 (0xCA included) returns the block to the locked state.
- R4: While the block is unlocked, any key write (0xFF or any other value) locks it again.
- R5: While the block is locked, writes to time (0x00), date (0x04), prescaler (0x10) and control (0x18), and to the init bit, are dropped with no visible effect.
- R6: Setting the init bit (bit 7 at offset 0x0C) while unlocked raises the ready flag (bit 6 at offset 0x0C) and freeze_o exactly SYNC_STAGES (default 2) clock edges after the write edge. Clearing the init bit drops both on the edge of that write.
- R7: When the block is unlocked and ready, a time or date write asserts time_load_o or date_load_o for exactly one cycle after the write edge, with load_data_o set to the written word, and a prescaler write updates prescaler_o on that edge. When the block is not ready, these writes are dropped.
- R8: The synced flag is bit 5 at offset 0x0C. Writing 0 to bit 5 clears it whether the block is locked or not, and writing 1 to bit 5 has no effect. A shadow_tick_i pulse while the block is not ready copies the live time and date into the shadows and sets the flag. If a tick and a clear arrive in the same cycle, the set takes effect. A tick while the block is ready is ignored.
- R9: With the bypass bit (bit 5 of control) set, reads at 0x00 and 0x04 return live_time_i and live_date_i. With it clear, those reads return the shadow copies. bypass_o shows the bit.
- R10: bus_rdata_o follows bus_addr_i combinationally. The key register reads 0, and offsets that are not decoded read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_we_i | input | 1 | Write strobe, one word per cycle |
| bus_addr_i | input | ADDR_W | Byte offset for read and write |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Read data for bus_addr_i |
| live_time_i | input | DATA_W | Running time value from the core |
| live_date_i | input | DATA_W | Running date value from the core |
| shadow_tick_i | input | 1 | Core refresh point for the shadow copies |
| freeze_o | output | 1 | Init ready; holds the calendar core |
| time_load_o | output | 1 | One-cycle strobe that loads a new time |
| date_load_o | output | 1 | One-cycle strobe that loads a new date |
| load_data_o | output | DATA_W | Word carried by the load strobes |
| prescaler_o | output | PRESC_W | Prescaler setting for the core |
| bypass_o | output | 1 | Shadow bypass setting |

## Verification
Read data is due in the same cycle as the address. Load strobes, the prescaler, control and synced-flag updates, and relocking are due on the first edge after the write. The ready flag is due SYNC_STAGES edges after the init write. The bench drives every input at the falling edge and compares all outputs one time step later against a behavioural model. The model steps once per rising edge using only the inputs it drove, so each result is checked in the exact cycle it is due, with no earlier or later tolerance.

// File: rtl/cwg_pkg.sv
package cwg_pkg;
  localparam int unsigned OFF_TIME  = 'h00;
  localparam int unsigned OFF_DATE  = 'h04;
  localparam int unsigned OFF_STAT  = 'h0C;
  localparam int unsigned OFF_PRESC = 'h10;
  localparam int unsigned OFF_CTRL  = 'h18;
  localparam int unsigned OFF_KEY   = 'h24;

  localparam logic [7:0] KEY_FIRST  = 8'hCA;
  localparam logic [7:0] KEY_SECOND = 8'h53;

  localparam int BIT_SYNCED = 5;
  localparam int BIT_READY  = 6;
  localparam int BIT_INIT   = 7;
  localparam int BIT_BYPASS = 5;

  typedef enum logic [1:0] {
    LK_SHUT = 2'd0,
    LK_HALF = 2'd1,
    LK_OPEN = 2'd2
  } lock_e;
endpackage

// File: rtl/cwg_key_gate.sv
module cwg_key_gate
  import cwg_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       key_we_i,
  input  logic [7:0] key_i,
  output logic       unlocked_o
);
  lock_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (key_we_i) begin
      unique case (state_q)
        LK_SHUT: state_d = (key_i == KEY_FIRST)  ? LK_HALF : LK_SHUT;
        LK_HALF: state_d = (key_i == KEY_SECOND) ? LK_OPEN : LK_SHUT;
        default: state_d = LK_SHUT;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= LK_SHUT;
    else         state_q <= state_d;
  end

  assign unlocked_o = (state_q == LK_OPEN);
endmodule

// File: rtl/cwg_init_sync.sv
module cwg_init_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  output logic ready_o
);
  logic [SYNC_STAGES-1:0] stg_q;

  for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[i] <= 1'b0;
      else if (i == 0) stg_q[i] <= req_i;
      else stg_q[i] <= req_i & stg_q[(i == 0) ? 0 : i-1];
    end
  end

  // dropping the request drops ready at once
  assign ready_o = req_i & stg_q[SYNC_STAGES-1];
endmodule

// File: rtl/cwg_shadow_bank.sv
module cwg_shadow_bank #(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              hold_i,
  input  logic              synced_clr_i,
  input  logic [DATA_W-1:0] live_time_i,
  input  logic [DATA_W-1:0] live_date_i,
  output logic [DATA_W-1:0] shadow_time_o,
  output logic [DATA_W-1:0] shadow_date_o,
  output logic              synced_o
);
  logic refresh;
  assign refresh = tick_i & ~hold_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shadow_time_o <= '0;
      shadow_date_o <= '0;
    end else if (refresh) begin
      shadow_time_o <= live_time_i;
      shadow_date_o <= live_date_i;
    end
  end

  // set has priority over software clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           synced_o <= 1'b0;
    else if (refresh)      synced_o <= 1'b1;
    else if (synced_clr_i) synced_o <= 1'b0;
  end
endmodule

// File: rtl/calendar_write_guard.sv
module calendar_write_guard
  import cwg_pkg::*;
#(
  parameter int                  ADDR_W      = 8,
  parameter int                  DATA_W      = 32,
  parameter int                  PRESC_W     = 23,
  parameter int                  CTRL_W      = 8,
  parameter int                  SYNC_STAGES = 2,
  parameter logic [PRESC_W-1:0]  PRESC_RST   = 'h7F00FF
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               bus_we_i,
  input  logic [ADDR_W-1:0]  bus_addr_i,
  input  logic [DATA_W-1:0]  bus_wdata_i,
  output logic [DATA_W-1:0]  bus_rdata_o,
  input  logic [DATA_W-1:0]  live_time_i,
  input  logic [DATA_W-1:0]  live_date_i,
  input  logic               shadow_tick_i,
  output logic               freeze_o,
  output logic               time_load_o,
  output logic               date_load_o,
  output logic [DATA_W-1:0]  load_data_o,
  output logic [PRESC_W-1:0] prescaler_o,
  output logic               bypass_o
);
  localparam logic [ADDR_W-1:0] A_TIME  = ADDR_W'(OFF_TIME);
  localparam logic [ADDR_W-1:0] A_DATE  = ADDR_W'(OFF_DATE);
  localparam logic [ADDR_W-1:0] A_STAT  = ADDR_W'(OFF_STAT);
  localparam logic [ADDR_W-1:0] A_PRESC = ADDR_W'(OFF_PRESC);
  localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(OFF_CTRL);
  localparam logic [ADDR_W-1:0] A_KEY   = ADDR_W'(OFF_KEY);

  logic sel_time, sel_date, sel_stat, sel_presc, sel_ctrl, sel_key;
  logic unlocked, ready, load_ok, synced, synced_clr;
  logic init_req_q;
  logic [CTRL_W-1:0] ctrl_q;
  logic [DATA_W-1:0] shadow_time, shadow_date;

  assign sel_time  = bus_we_i && (bus_addr_i == A_TIME);
  assign sel_date  = bus_we_i && (bus_addr_i == A_DATE);
  assign sel_stat  = bus_we_i && (bus_addr_i == A_STAT);
  assign sel_presc = bus_we_i && (bus_addr_i == A_PRESC);
  assign sel_ctrl  = bus_we_i && (bus_addr_i == A_CTRL);
  assign sel_key   = bus_we_i && (bus_addr_i == A_KEY);

  cwg_key_gate u_key (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .key_we_i   (sel_key),
    .key_i      (bus_wdata_i[7:0]),
    .unlocked_o (unlocked)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  init_req_q <= 1'b0;
    else if (sel_stat && unlocked) init_req_q <= bus_wdata_i[BIT_INIT];
  end

  cwg_init_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (init_req_q),
    .ready_o (ready)
  );

  assign synced_clr = sel_stat && !bus_wdata_i[BIT_SYNCED];

  cwg_shadow_bank #(.DATA_W(DATA_W)) u_shadow (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .tick_i        (shadow_tick_i),
    .hold_i        (ready),
    .synced_clr_i  (synced_clr),
    .live_time_i   (live_time_i),
    .live_date_i   (live_date_i),
    .shadow_time_o (shadow_time),
    .shadow_date_o (shadow_date),
    .synced_o      (synced)
  );

  assign load_ok = unlocked && ready;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      time_load_o <= 1'b0;
      date_load_o <= 1'b0;
      load_data_o <= '0;
    end else begin
      time_load_o <= sel_time && load_ok;
      date_load_o <= sel_date && load_ok;
      if ((sel_time || sel_date) && load_ok) load_data_o <= bus_wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 prescaler_o <= PRESC_RST;
    else if (sel_presc && load_ok) prescaler_o <= bus_wdata_i[PRESC_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   ctrl_q <= '0;
    else if (sel_ctrl && unlocked) ctrl_q <= bus_wdata_i[CTRL_W-1:0];
  end

  assign bypass_o = ctrl_q[BIT_BYPASS];
  assign freeze_o = ready;

  always_comb begin
    bus_rdata_o = '0;
    unique case (bus_addr_i)
      A_TIME:  bus_rdata_o = bypass_o ? live_time_i : shadow_time;
      A_DATE:  bus_rdata_o = bypass_o ? live_date_i : shadow_date;
      A_STAT: begin
        bus_rdata_o[BIT_INIT]   = init_req_q;
        bus_rdata_o[BIT_READY]  = ready;
        bus_rdata_o[BIT_SYNCED] = synced;
      end
      A_PRESC: bus_rdata_o = DATA_W'(prescaler_o);
      A_CTRL:  bus_rdata_o = DATA_W'(ctrl_q);
      default: bus_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/cwg_guard_chk.sv
module cwg_guard_chk
  import cwg_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int PRESC_W     = 23,
  parameter int SYNC_STAGES = 2
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               bus_we_i,
  input logic [ADDR_W-1:0]  bus_addr_i,
  input logic               shadow_tick_i,
  input logic               freeze_o,
  input logic               time_load_o,
  input logic               date_load_o,
  input logic [PRESC_W-1:0] prescaler_o,
  input logic               unlocked,
  input logic               init_req,
  input logic               synced
);
  localparam int AGE_W = $clog2(SYNC_STAGES + 2) + 1;
  logic [AGE_W-1:0] req_age;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                           req_age <= '0;
    else if (!init_req)                    req_age <= '0;
    else if (req_age < AGE_W'(SYNC_STAGES)) req_age <= req_age + 1'b1;
  end

  logic key_wr, time_wr, presc_wr;
  assign key_wr   = bus_we_i && (bus_addr_i == ADDR_W'(OFF_KEY));
  assign time_wr  = bus_we_i && (bus_addr_i == ADDR_W'(OFF_TIME));
  assign presc_wr = bus_we_i && (bus_addr_i == ADDR_W'(OFF_PRESC));

  // R6
  ready_delay_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(freeze_o) |-> req_age == AGE_W'(SYNC_STAGES));
  // R6
  ready_needs_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    freeze_o |-> init_req);
  // R7
  time_load_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    time_load_o |-> $past(time_wr && unlocked && freeze_o));
  // R7
  load_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({time_load_o, date_load_o}));
  // R5
  presc_guard_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(prescaler_o) |-> $past(presc_wr && unlocked && freeze_o));
  // R4
  relock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (key_wr && unlocked) |=> !unlocked);
  // R2
  unlock_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(unlocked) |-> $past(key_wr));
  // R8
  synced_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(synced) |-> $past(shadow_tick_i && !freeze_o));
endmodule

bind calendar_write_guard cwg_guard_chk #(
  .ADDR_W(ADDR_W), .PRESC_W(PRESC_W), .SYNC_STAGES(SYNC_STAGES)
) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .bus_we_i      (bus_we_i),
  .bus_addr_i    (bus_addr_i),
  .shadow_tick_i (shadow_tick_i),
  .freeze_o      (freeze_o),
  .time_load_o   (time_load_o),
  .date_load_o   (date_load_o),
  .prescaler_o   (prescaler_o),
  .unlocked      (unlocked),
  .init_req      (init_req_q),
  .synced        (synced)
);

// File: tb/calendar_write_guard_test.sv
module calendar_write_guard_test;
  localparam int SYNC = 2;
  localparam logic [31:0] PRESC_MASK = 32'h007F_FFFF;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic we_r = 1'b0;
  logic [7:0] addr_r = '0;
  logic [31:0] wd_r = '0;
  logic tick_r = 1'b0;
  logic [31:0] live_t = 32'h0012_3456;
  logic [31:0] live_d = 32'h0025_0611;

  logic [31:0] rdata, load_data;
  logic [22:0] presc;
  logic freeze, tload, dload, bypass;

  always #10 clk = ~clk;

  calendar_write_guard uut (
    .clk_i(clk), .rst_ni(rst_n), .bus_we_i(we_r), .bus_addr_i(addr_r),
    .bus_wdata_i(wd_r), .bus_rdata_o(rdata), .live_time_i(live_t),
    .live_date_i(live_d), .shadow_tick_i(tick_r), .freeze_o(freeze),
    .time_load_o(tload), .date_load_o(dload), .load_data_o(load_data),
    .prescaler_o(presc), .bypass_o(bypass)
  );

  int checks = 0;
  int fails = 0;
  bit done = 0;
  string tag = "R1";

  // behavioural reference
  int m_lock = 0;
  bit m_init = 0;
  int m_cnt = 0;
  bit m_rsf = 0;
  logic [31:0] m_presc = 32'h007F_00FF;
  logic [31:0] m_ctrl = 0;
  logic [31:0] m_sht = 0, m_shd = 0, m_ld = 0;
  bit m_tl = 0, m_dl = 0;

  function automatic bit m_ready();
    return m_init && (m_cnt >= SYNC);
  endfunction

  function automatic logic [31:0] m_rdata(input logic [7:0] a);
    case (a)
      8'h00: return m_ctrl[5] ? live_t : m_sht;
      8'h04: return m_ctrl[5] ? live_d : m_shd;
      8'h0C: return (32'(m_init) << 7) | (32'(m_ready()) << 6) | (32'(m_rsf) << 5);
      8'h10: return m_presc;
      8'h18: return m_ctrl;
      default: return 32'h0;
    endcase
  endfunction

  task automatic model_step();
    bit rdy = m_ready();
    bit unl = (m_lock == 2);
    m_cnt = m_init ? ((m_cnt < SYNC) ? m_cnt + 1 : m_cnt) : 0;
    m_tl = 0; m_dl = 0;
    if (we_r) begin
      case (addr_r)
        8'h24: m_lock = (m_lock == 0) ? ((wd_r[7:0] == 8'hCA) ? 1 : 0)
                      : (m_lock == 1) ? ((wd_r[7:0] == 8'h53) ? 2 : 0) : 0;
        8'h00: if (unl && rdy) begin m_tl = 1; m_ld = wd_r; end
        8'h04: if (unl && rdy) begin m_dl = 1; m_ld = wd_r; end
        8'h0C: begin
          if (unl) m_init = wd_r[7];
          if (!wd_r[5]) m_rsf = 0;
        end
        8'h10: if (unl && rdy) m_presc = wd_r & PRESC_MASK;
        8'h18: if (unl) m_ctrl = wd_r & 32'hFF;
        default: ;
      endcase
    end
    if (tick_r && !rdy) begin m_sht = live_t; m_shd = live_d; m_rsf = 1; end
  endtask

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic compare();
    chk("freeze", 32'(freeze), 32'(m_ready()));
    chk("time_load", 32'(tload), 32'(m_tl));
    chk("date_load", 32'(dload), 32'(m_dl));
    chk("load_data", load_data, m_ld);
    chk("prescaler", 32'(presc), m_presc);
    chk("bypass", 32'(bypass), 32'(m_ctrl[5]));
    chk("rdata", rdata, m_rdata(addr_r));
  endtask

  task automatic cyc(input bit we, input logic [7:0] a, input logic [31:0] d, input bit tk);
    @(negedge clk);
    we_r = we; addr_r = a; wd_r = d; tick_r = tk;
    live_t = live_t + 32'h0101_0007;
    live_d = live_d + 32'h3;
    #1 compare();
    @(posedge clk);
    model_step();
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    cyc(1, a, d, 0);
  endtask

  task automatic rd(input logic [7:0] a, input int n);
    for (int i = 0; i < n; i++) cyc(0, a, 0, 0);
  endtask

  task automatic unlock();
    wr(8'h24, 32'h0000_00CA);
    wr(8'h24, 32'h0000_0053);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    tag = "R1";
    rd(8'h0C, 1); rd(8'h10, 1); rd(8'h18, 1); rd(8'h00, 1); rd(8'h04, 1);

    tag = "R5";
    wr(8'h18, 32'h20); wr(8'h0C, 32'hA0); wr(8'h10, 32'h1234);
    wr(8'h00, 32'h0011_2233); wr(8'h04, 32'h0044_5566);
    rd(8'h18, 2); rd(8'h0C, 3);

    tag = "R3";
    wr(8'h24, 32'h53); wr(8'h18, 32'h20); rd(8'h18, 1);
    wr(8'h24, 32'hCA); wr(8'h24, 32'hCA); wr(8'h24, 32'h53); wr(8'h18, 32'h20); rd(8'h18, 1);
    wr(8'h24, 32'hCA); wr(8'h24, 32'h11); wr(8'h24, 32'h53); wr(8'h18, 32'h20); rd(8'h18, 1);

    tag = "R2";
    wr(8'h24, 32'hABCD_00CA); wr(8'h24, 32'h1234_5653);
    wr(8'h18, 32'h0000_0101); rd(8'h18, 1);

    tag = "R7";
    wr(8'h00, 32'h0001_0203); wr(8'h10, 32'h0000_7777); rd(8'h10, 1);

    tag = "R6";
    wr(8'h0C, 32'h80); rd(8'h0C, 4);

    tag = "R7";
    wr(8'h00, 32'h0013_4500); rd(8'h00, 1);
    wr(8'h04, 32'h0025_1231); rd(8'h04, 1);
    wr(8'h10, 32'hFF12_3456); rd(8'h10, 1);
    wr(8'h00, 32'h0000_0001); wr(8'h04, 32'h0000_0002); rd(8'h0C, 1);

    tag = "R8";
    cyc(0, 8'h0C, 0, 1); rd(8'h00, 1);

    tag = "R6";
    wr(8'h0C, 32'h00); rd(8'h0C, 2);
    wr(8'h0C, 32'h80); wr(8'h0C, 32'h00); wr(8'h0C, 32'h80); rd(8'h0C, 3);
    wr(8'h0C, 32'h00);

    tag = "R8";
    cyc(0, 8'h0C, 0, 1); rd(8'h00, 1); rd(8'h04, 1);
    wr(8'h0C, 32'h20); rd(8'h0C, 1);
    wr(8'h0C, 32'h00); rd(8'h0C, 1);
    cyc(1, 8'h0C, 32'h00, 1); rd(8'h0C, 1);

    tag = "R9";
    wr(8'h18, 32'h20); rd(8'h00, 3); rd(8'h04, 2);
    wr(8'h18, 32'h00); rd(8'h00, 2);

    tag = "R4";
    wr(8'h24, 32'hFF); wr(8'h18, 32'h20); rd(8'h18, 1);
    unlock(); wr(8'h24, 32'h99); wr(8'h18, 32'h20); rd(8'h18, 1);
    unlock(); wr(8'h24, 32'h53); wr(8'h18, 32'h20); rd(8'h18, 1);

    tag = "R8";
    cyc(0, 8'h0C, 0, 1); wr(8'h0C, 32'h00); rd(8'h0C, 1);

    tag = "R10";
    rd(8'h24, 1); rd(8'h3C, 1); rd(8'h08, 1);
    cyc(0, 8'h0C, 0, 1); rd(8'h14, 1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule